// File: doc/BRIEF.md
# Core Run Control Register

This block is the single 32-bit control and status word through which a host or debug agent starts, stops, single-steps and resets a small embedded processor core. Writes arrive on a plain write strobe with a full data word. A registered read word is refreshed every cycle from the stored fields and from the core's live status lines.

Toward the core the block drives:
- a fetch enable,
- a single-step policy flag,
- a one-cycle active-low soft reset,
- a one-cycle wake request,
- a cycle-counter enable,
- the program-counter value used after reset.

From the core it takes a busy flag, a flag showing that a multi-cycle instruction is past its first cycle, a retire strobe, a sleep flag and an endianness flag.

Clearing the enable normally stops the fetch enable at once. When a multi-cycle instruction is under way, the fetch enable is held until that instruction retires. In single-step mode the block clears the enable by itself when one instruction retires.

Top module: `run_ctl_reg`

## Requirements
- R1: After synchronous reset, fetch_en, step_mode, cyc_cnt_en and wake_req are 0, reset_pc is 0 and soft_rst_n is 1. One cycle after reset is released, with all core inputs low, rd_data reads 32'h0000_0001.
- R2: Bits 31:16 of a write are stored as the reset program counter. They appear on reset_pc in the cycle after the write and read back in those bits.
- R3: rd_data bit 15 reports core_busy, bit 14 reports core_big_endian and bit 2 reports core_asleep, each one cycle after the input is sampled. Writes to these bits do not change them.
- R4: Bits 13:9 and 7:4 of rd_data always read 0, whatever was written to them.
- R5: Bit 8 is the single-step policy. It drives step_mode from the cycle after the write and reads back. Setting it alone leaves fetch_en at 0.
- R6: Bit 1 is the enable. Writing 1 raises fetch_en in the next cycle. Writing 0 while core_multi_busy is low drops fetch_en in the next cycle.
- R7: Writing 0 to bit 1 while fetch_en is high and core_multi_busy is high makes bit 1 read 0 right away. fetch_en stays high until the cycle after core_retire.
- R8: With bit 8 and bit 1 both set, and both may be set by one write, a core_retire pulse clears bit 1. fetch_en falls in the next cycle, and bit 8 keeps its value.
- R9: Writing 1 to bit 1 after a halt raises fetch_en again without any soft reset pulse, so soft_rst_n stays 1.
- R10: Bit 3 drives cyc_cnt_en from the cycle after the write and reads back.
- R11: Writing 0 to bit 2 while core_asleep is high gives a wake_req pulse one cycle long, in the cycle after the write. Writing 1, or writing 0 while the core is awake, gives no pulse.
- R12: Writing 0 to bit 0 drives soft_rst_n low for exactly the one cycle after the write. soft_rst_n then returns to 1 and bit 0 reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read word |
| core_busy | input | 1 | Core is executing |
| core_multi_busy | input | 1 | Multi-cycle instruction past its first cycle |
| core_retire | input | 1 | One-cycle instruction-retired strobe |
| core_asleep | input | 1 | Core is in sleep |
| core_big_endian | input | 1 | Core is in big-endian mode |
| fetch_en | output | 1 | Fetch enable to the core |
| step_mode | output | 1 | Single-step policy to the core |
| soft_rst_n | output | 1 | Active-low soft reset pulse |
| wake_req | output | 1 | Wake pulse to the core |
| cyc_cnt_en | output | 1 | Cycle counter enable |
| reset_pc | output | 16 | Program counter used after reset |

## Verification
Every core-facing output is registered. Each one is therefore due in the cycle after the write edge or retire edge that causes it. The read word is one register further on, so it is due one cycle after the stored field changes, and one cycle after a live status input is sampled. The bench drives its inputs on the falling edge. It compares the outputs at the next falling edge, and compares rd_data one falling edge later. Where a result must persist, such as the held enable during a multi-cycle instruction or the end of the one-cycle reset and wake pulses, it checks each of the following falling edges.

// File: rtl/run_ctl_pkg.sv
package run_ctl_pkg;
  localparam int FLD_W     = 16;
  localparam int BIT_RUN   = 15;
  localparam int BIT_BIG   = 14;
  localparam int BIT_STEP  = 8;
  localparam int BIT_CCE   = 3;
  localparam int BIT_SLP   = 2;
  localparam int BIT_EN    = 1;
  localparam int BIT_SRST  = 0;
endpackage

// File: rtl/run_ctl_fields.sv
module run_ctl_fields #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_step,
  input  logic            wr_cce,
  output logic [PC_W-1:0] pc_q,
  output logic            step_q,
  output logic            cce_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      step_q <= 1'b0;
      cce_q  <= 1'b0;
    end else if (wr_en) begin
      pc_q   <= wr_pc;
      step_q <= wr_step;
      cce_q  <= wr_cce;
    end
  end
endmodule

// File: rtl/run_ctl_halt.sv
module run_ctl_halt (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_enable_bit,
  input  logic step_q,
  input  logic multi_busy,
  input  logic retire,
  output logic en_q,
  output logic fetch_en
);
  logic hold_q;
  logic en_d, hold_d, clr_wr, step_done;

  always_comb begin
    clr_wr    = wr_en && !wr_enable_bit;
    step_done = en_q && step_q && retire;
    if (wr_en)          en_d = wr_enable_bit;
    else if (step_done) en_d = 1'b0;
    else                en_d = en_q;
    // keep fetching only while a started multi-cycle op is still unfinished
    hold_d = (hold_q || (clr_wr && en_q)) && multi_busy && !retire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      hold_q   <= 1'b0;
      fetch_en <= 1'b0;
    end else begin
      en_q     <= en_d;
      hold_q   <= hold_d;
      fetch_en <= en_d || hold_d;
    end
  end
endmodule

// File: rtl/run_ctl_pulse.sv
module run_ctl_pulse #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  generate
    if (ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b1;
        else     pulse_o <= !fire;
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= fire;
      end
    end
  endgenerate
endmodule

// File: rtl/run_ctl_reg.sv
module run_ctl_reg #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              core_busy,
  input  logic              core_multi_busy,
  input  logic              core_retire,
  input  logic              core_asleep,
  input  logic              core_big_endian,
  output logic              fetch_en,
  output logic              step_mode,
  output logic              soft_rst_n,
  output logic              wake_req,
  output logic              cyc_cnt_en,
  output logic [PC_W-1:0]   reset_pc
);
  import run_ctl_pkg::*;

  localparam int PC_LSB = DATA_W - PC_W;

  logic [PC_W-1:0]   pc_q;
  logic              step_q, cce_q, en_q;
  logic              srst_fire, wake_fire;
  logic [DATA_W-1:0] status_w;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[BIT_RUN:BIT_STEP+1], wr_data[BIT_STEP-1:BIT_CCE+1]};

  run_ctl_fields #(.PC_W(PC_W)) fields_i (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_pc(wr_data[PC_LSB +: PC_W]),
    .wr_step(wr_data[BIT_STEP]), .wr_cce(wr_data[BIT_CCE]),
    .pc_q(pc_q), .step_q(step_q), .cce_q(cce_q)
  );

  run_ctl_halt halt_i (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_enable_bit(wr_data[BIT_EN]), .step_q(step_q),
    .multi_busy(core_multi_busy), .retire(core_retire),
    .en_q(en_q), .fetch_en(fetch_en)
  );

  assign srst_fire = wr_en && !wr_data[BIT_SRST];
  assign wake_fire = wr_en && !wr_data[BIT_SLP] && core_asleep;

  run_ctl_pulse #(.ACTIVE_LOW(1'b1)) srst_i (
    .clk(clk), .rst(rst), .fire(srst_fire), .pulse_o(soft_rst_n)
  );

  run_ctl_pulse #(.ACTIVE_LOW(1'b0)) wake_i (
    .clk(clk), .rst(rst), .fire(wake_fire), .pulse_o(wake_req)
  );

  always_comb begin
    status_w                   = '0;
    status_w[PC_LSB +: PC_W]   = pc_q;
    status_w[BIT_RUN]          = core_busy;
    status_w[BIT_BIG]          = core_big_endian;
    status_w[BIT_STEP]         = step_q;
    status_w[BIT_CCE]          = cce_q;
    status_w[BIT_SLP]          = core_asleep;
    status_w[BIT_EN]           = en_q;
    status_w[BIT_SRST]         = soft_rst_n;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= {{(DATA_W-1){1'b0}}, 1'b1};
    else     rd_data <= status_w;
  end

  assign step_mode  = step_q;
  assign cyc_cnt_en = cce_q;
  assign reset_pc   = pc_q;
endmodule

// File: rtl/run_ctl_reg_chk.sv
module run_ctl_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [2:0] wr_lo,
  input logic       core_multi_busy,
  input logic       core_retire,
  input logic       core_asleep,
  input logic       fetch_en,
  input logic       step_mode,
  input logic       soft_rst_n,
  input logic       wake_req
);
  // R6
  imm_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_lo[1] && !core_multi_busy) |=> !fetch_en);

  // R7
  defer_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && wr_en && !wr_lo[1] && core_multi_busy && !core_retire) |=> fetch_en);

  // R8
  step_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && step_mode && core_retire && !wr_en) |=> !fetch_en);

  // R11
  wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_lo[2] && core_asleep) |=> wake_req);

  // R12
  srst_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_lo[0]) |=> !soft_rst_n);

  // R12
  srst_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst_n && !(wr_en && !wr_lo[0])) |=> soft_rst_n);
endmodule

bind run_ctl_reg run_ctl_reg_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lo(wr_data[2:0]),
  .core_multi_busy(core_multi_busy), .core_retire(core_retire),
  .core_asleep(core_asleep), .fetch_en(fetch_en), .step_mode(step_mode),
  .soft_rst_n(soft_rst_n), .wake_req(wake_req)
);

// File: tb/run_ctl_reg_tb.sv
`timescale 1ns/1ps
module run_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        core_busy = 1'b0, core_multi_busy = 1'b0, core_retire = 1'b0;
  logic        core_asleep = 1'b0, core_big_endian = 1'b0;
  logic        fetch_en, step_mode, soft_rst_n, wake_req, cyc_cnt_en;
  logic [15:0] reset_pc;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  run_ctl_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_busy(core_busy), .core_multi_busy(core_multi_busy),
    .core_retire(core_retire), .core_asleep(core_asleep),
    .core_big_endian(core_big_endian), .fetch_en(fetch_en),
    .step_mode(step_mode), .soft_rst_n(soft_rst_n), .wake_req(wake_req),
    .cyc_cnt_en(cyc_cnt_en), .reset_pc(reset_pc)
  );

  // {write word, expected read word}; bit 0 kept at 1 so no reset pulse
  localparam logic [63:0] VEC [6] = '{
    {32'hABCD_0001, 32'hABCD_0001},
    {32'hFFFF_FFFF, 32'hFFFF_010B},
    {32'h1234_7EF5, 32'h1234_0001},
    {32'h0000_0109, 32'h0000_0109},
    {32'h8001_000B, 32'h8001_000B},
    {32'h0000_0001, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic retire_pulse();
    core_retire = 1'b1;
    @(negedge clk);
    core_retire = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 fetch_en", 32'(fetch_en), 0);
    chk("R1 step_mode", 32'(step_mode), 0);
    chk("R1 cyc_cnt_en", 32'(cyc_cnt_en), 0);
    chk("R1 wake_req", 32'(wake_req), 0);
    chk("R1 soft_rst_n", 32'(soft_rst_n), 1);
    chk("R1 reset_pc", 32'(reset_pc), 0);
    @(negedge clk);
    chk("R1 rd_data", rd_data, 32'h0000_0001);

    // R3 live status bits
    core_busy = 1'b1; core_big_endian = 1'b1; core_asleep = 1'b1;
    @(negedge clk);
    chk("R3 status set", {29'b0, rd_data[15], rd_data[14], rd_data[2]}, 32'h7);
    core_busy = 1'b0; core_big_endian = 1'b0; core_asleep = 1'b0;
    @(negedge clk);
    chk("R3 status clear", {29'b0, rd_data[15], rd_data[14], rd_data[2]}, 32'h0);

    // table walk: R2 R4 R5 R10 and R3 write-ignore
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][63:32]);
      chk("R2 reset_pc", 32'(reset_pc), 32'(VEC[i][63:48]));
      chk("R5 step_mode", 32'(step_mode), 32'(VEC[i][40]));
      chk("R10 cyc_cnt_en", 32'(cyc_cnt_en), 32'(VEC[i][35]));
      chk("R5 R6 fetch_en", 32'(fetch_en), 32'(VEC[i][33]));
      @(negedge clk);
      chk("R4 rd_data", rd_data, VEC[i][31:0]);
    end

    // R6 immediate halt
    wr(32'h3);
    chk("R6 enable", 32'(fetch_en), 1);
    wr(32'h1);
    chk("R6 immediate halt", 32'(fetch_en), 0);

    // R7 deferred halt
    wr(32'h3);
    core_multi_busy = 1'b1;
    wr(32'h1);
    chk("R7 held", 32'(fetch_en), 1);
    @(negedge clk);
    chk("R7 bit1 reads 0", 32'(rd_data[1]), 0);
    chk("R7 still held", 32'(fetch_en), 1);
    @(negedge clk);
    chk("R7 still held 2", 32'(fetch_en), 1);
    retire_pulse();
    core_multi_busy = 1'b0;
    chk("R7 release", 32'(fetch_en), 0);

    // R9 resume
    wr(32'h3);
    chk("R9 resume", 32'(fetch_en), 1);
    chk("R9 no reset", 32'(soft_rst_n), 1);

    // R8 single step from one write
    wr(32'h1);
    wr(32'h103);
    chk("R8 running", 32'(fetch_en), 1);
    chk("R8 step_mode", 32'(step_mode), 1);
    @(negedge clk);
    chk("R8 bit1 set", 32'(rd_data[1]), 1);
    retire_pulse();
    chk("R8 stopped", 32'(fetch_en), 0);
    @(negedge clk);
    chk("R8 bit1/bit8", {30'b0, rd_data[8], rd_data[1]}, 32'h2);

    // R11 wake
    core_asleep = 1'b1;
    wr(32'h5);
    chk("R11 write 1 no wake", 32'(wake_req), 0);
    wr(32'h1);
    chk("R11 wake pulse", 32'(wake_req), 1);
    @(negedge clk);
    chk("R11 pulse ends", 32'(wake_req), 0);
    core_asleep = 1'b0;
    wr(32'h1);
    chk("R11 awake no wake", 32'(wake_req), 0);

    // R12 soft reset
    wr(32'h0);
    chk("R12 low", 32'(soft_rst_n), 0);
    @(negedge clk);
    chk("R12 restored", 32'(soft_rst_n), 1);
    @(negedge clk);
    chk("R12 bit0 reads 1", 32'(rd_data[0]), 1);

    finish_run();
  end
endmodule